// File: doc/BRIEF.md
# Integer Execute Unit with Condition, Overflow and Shift-Count State

This block is the integer execute stage of a 32-bit core. Each cycle it takes two register operands, a 16-bit immediate and an opcode, and it produces a 32-bit result combinationally. Alongside the result it keeps three pieces of architectural state in registers: a condition flag, an overflow flag and a 5-bit shift count. Only a cycle with `valid` high may update that state. Each opcode has its own rule for the flags.

The supported operations are:

- signed and unsigned addition and subtraction;
- four bitwise operations, each with a form that places the immediate in the upper half-word;
- left, right and arithmetic-right shifts;
- a funnel shift of the 64-bit pair {srcA, srcB}, which shifts right by the count captured on an earlier logical right shift.

The surrounding pipeline reads the result in the cycle the operands are presented. It sees the flags from the next cycle on.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 0 (signed add) returns srcA+srcB modulo 2^32. The overflow flag is set when the sum overflows as a signed value. The condition flag is set when srcB is less than (0 - srcA) modulo 2^32, both compared as signed values.
- R2: Opcode 1 (unsigned add) returns srcA+srcB. Both the condition flag and the overflow flag take the carry out of the top bit.
- R3: Opcode 2 (signed subtract) returns srcA-srcB. The overflow flag is set on signed overflow. The condition flag is set when srcB > srcA as signed values.
- R4: Opcode 3 (unsigned subtract) returns srcA-srcB. The condition flag is set when srcB <= srcA as unsigned values. The overflow flag is the inverse of the condition flag.
- R5: Opcodes 4, 6, 8 and 10 return, in that order, srcA AND srcB, (NOT srcA) AND srcB, srcA OR srcB, and srcA XOR srcB. The condition flag is set exactly when the result is zero. The overflow flag keeps its value.
- R6: Opcodes 5, 7, 9 and 11 are the same four operations with srcA replaced by {imm, 16'h0}. Opcode 7 inverts that whole 32-bit value before the AND. The flag rules of R5 apply.
- R7: Opcode 12 shifts srcB left, opcode 13 shifts it right with zero fill, and opcode 14 shifts it right with sign fill. The amount is srcA[4:0]. Opcode 13 also loads srcA[4:0] into the shift count.
- R8: Opcode 15 returns the low 32 bits of {srcA, srcB} shifted right by the stored shift count, that is, the count as it stood before this cycle.
- R9: The flags and the shift count change only at a clock edge where `valid` is high. Shift opcodes leave the condition and overflow flags unchanged. Every opcode except 13 leaves the shift count unchanged.
- R10: An active-low reset clears the condition flag, the overflow flag and the shift count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Qualifies the operation for a state update |
| opcode | input | 4 | Operation select, codes as listed in the requirements |
| srcA | input | 32 | First operand; its low 5 bits give the shift amount |
| srcB | input | 32 | Second operand |
| imm | input | 16 | Immediate used by the high-half forms |
| result | output | 32 | Combinational result |
| ccFlag | output | 1 | Registered condition flag |
| ofFlag | output | 1 | Registered overflow flag |
| shiftCount | output | 5 | Registered shift count |

## Verification
The result is valid in the same cycle as its operands. The bench drives inputs at the falling edge and compares `result` one nanosecond later, before any clock edge intervenes. The flags and the shift count are due one rising edge after the operation. They are compared one nanosecond after that edge, against a reference state that advances only on valid operations. A funnel shift placed directly after a logical right shift shows that the count loaded by the right shift is used on the following cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADDS  = 4'd0,
    OP_ADDU  = 4'd1,
    OP_SUBS  = 4'd2,
    OP_SUBU  = 4'd3,
    OP_AND   = 4'd4,
    OP_ANDH  = 4'd5,
    OP_ANDN  = 4'd6,
    OP_ANDNH = 4'd7,
    OP_OR    = 4'd8,
    OP_ORH   = 4'd9,
    OP_XOR   = 4'd10,
    OP_XORH  = 4'd11,
    OP_SHL   = 4'd12,
    OP_SHR   = 4'd13,
    OP_SHRA  = 4'd14,
    OP_SHRD  = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    U_ARITH = 2'd0,
    U_LOGIC = 2'd1,
    U_SHIFT = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    L_AND = 2'd0,
    L_OR  = 2'd1,
    L_XOR = 2'd2
  } logicOp_e;

  typedef enum logic [1:0] {
    S_LEFT   = 2'd0,
    S_RIGHT  = 2'd1,
    S_ARITH  = 2'd2,
    S_DOUBLE = 2'd3
  } shiftOp_e;

  typedef struct packed {
    unit_e    unit;
    logic     subtract;
    logic     signedMode;
    logic     highImm;
    logic     invertSrc1;
    logicOp_e logicOp;
    shiftOp_e shiftOp;
    logic     ccWr;
    logic     ofWr;
    logic     scWr;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] opcode,
  output aluCtrl_t   strobes
);

  always_comb begin
    strobes = '0;
    case (aluOp_e'(opcode))
      OP_ADDS: begin
        strobes.unit       = U_ARITH;
        strobes.signedMode = 1'b1;
        strobes.ccWr       = valid;
        strobes.ofWr       = valid;
      end
      OP_ADDU: begin
        strobes.unit = U_ARITH;
        strobes.ccWr = valid;
        strobes.ofWr = valid;
      end
      OP_SUBS: begin
        strobes.unit       = U_ARITH;
        strobes.subtract   = 1'b1;
        strobes.signedMode = 1'b1;
        strobes.ccWr       = valid;
        strobes.ofWr       = valid;
      end
      OP_SUBU: begin
        strobes.unit     = U_ARITH;
        strobes.subtract = 1'b1;
        strobes.ccWr     = valid;
        strobes.ofWr     = valid;
      end
      OP_AND, OP_ANDH, OP_ANDN, OP_ANDNH: begin
        strobes.unit       = U_LOGIC;
        strobes.logicOp    = L_AND;
        strobes.highImm    = opcode[0];
        strobes.invertSrc1 = opcode[1];
        strobes.ccWr       = valid;
      end
      OP_OR, OP_ORH: begin
        strobes.unit    = U_LOGIC;
        strobes.logicOp = L_OR;
        strobes.highImm = opcode[0];
        strobes.ccWr    = valid;
      end
      OP_XOR, OP_XORH: begin
        strobes.unit    = U_LOGIC;
        strobes.logicOp = L_XOR;
        strobes.highImm = opcode[0];
        strobes.ccWr    = valid;
      end
      OP_SHL: begin
        strobes.unit    = U_SHIFT;
        strobes.shiftOp = S_LEFT;
      end
      OP_SHR: begin
        strobes.unit    = U_SHIFT;
        strobes.shiftOp = S_RIGHT;
        strobes.scWr    = valid;
      end
      OP_SHRA: begin
        strobes.unit    = U_SHIFT;
        strobes.shiftOp = S_ARITH;
      end
      default: begin
        strobes.unit    = U_SHIFT;
        strobes.shiftOp = S_DOUBLE;
      end
    endcase
  end

  // R9: at most one of arithmetic / logic / shift-count writes per cycle
  always_comb begin
    AST_ONE_STATE_CLASS: assert ($onehot0({strobes.ccWr & ~strobes.ofWr, strobes.ofWr, strobes.scWr})); // R9
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  aluCtrl_t           strobes,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  result,
  output logic               ccFlag,
  output logic               ofFlag,
  output logic [SHAMT_W-1:0] shiftCount
);

  localparam int MSB    = DATA_W - 1;
  localparam int PAIR_W = 2 * DATA_W;
  localparam int LOW_W  = DATA_W - IMM_W;

  // ---------------- arithmetic: one adder, operand inverted for subtract
  logic [DATA_W-1:0] addOperand;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumRes;
  logic [DATA_W-1:0] negA;
  logic              carryTop;
  logic              carryBelow;
  logic              signedOvf;
  logic              arithCc;
  logic              arithOf;

  assign addOperand = strobes.subtract ? ~srcB : srcB;
  assign sumWide    = {1'b0, srcA} + {1'b0, addOperand} + {{DATA_W{1'b0}}, strobes.subtract};
  assign sumRes     = sumWide[MSB:0];
  assign carryTop   = sumWide[DATA_W];
  assign carryBelow = srcA[MSB] ^ addOperand[MSB] ^ sumRes[MSB];
  assign signedOvf  = carryTop ^ carryBelow;
  assign negA       = '0 - srcA;

  always_comb begin
    unique case ({strobes.subtract, strobes.signedMode})
      2'b01:   arithCc = $signed(srcB) < $signed(negA);
      2'b11:   arithCc = $signed(srcB) > $signed(srcA);
      default: arithCc = carryTop;
    endcase
    if (strobes.signedMode)    arithOf = signedOvf;
    else if (strobes.subtract) arithOf = ~carryTop;
    else                       arithOf = carryTop;
  end

  // ---------------- bitwise unit
  logic [DATA_W-1:0] highVal;
  logic [DATA_W-1:0] firstSel;
  logic [DATA_W-1:0] firstOp;
  logic [DATA_W-1:0] logicRes;

  assign highVal  = {imm, {LOW_W{1'b0}}};
  assign firstSel = strobes.highImm ? highVal : srcA;
  assign firstOp  = strobes.invertSrc1 ? ~firstSel : firstSel;

  always_comb begin
    case (strobes.logicOp)
      L_OR:    logicRes = firstOp | srcB;
      L_XOR:   logicRes = firstOp ^ srcB;
      default: logicRes = firstOp & srcB;
    endcase
  end

  // ---------------- shifter
  logic [SHAMT_W-1:0] shamt;
  logic [PAIR_W-1:0]  pairVal;
  logic [PAIR_W-1:0]  pairShifted;
  logic [DATA_W-1:0]  shiftRes;

  assign shamt       = srcA[SHAMT_W-1:0];
  assign pairVal     = {srcA, srcB};
  assign pairShifted = pairVal >> shiftCount;

  always_comb begin
    case (strobes.shiftOp)
      S_LEFT:  shiftRes = srcB << shamt;
      S_RIGHT: shiftRes = srcB >> shamt;
      S_ARITH: shiftRes = $unsigned($signed(srcB) >>> shamt);
      default: shiftRes = pairShifted[DATA_W-1:0];
    endcase
  end

  // ---------------- result select
  always_comb begin
    case (strobes.unit)
      U_LOGIC: result = logicRes;
      U_SHIFT: result = shiftRes;
      default: result = sumRes;
    endcase
  end

  // ---------------- architectural state
  logic ccNext;
  assign ccNext = (strobes.unit == U_ARITH) ? arithCc : (logicRes == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccFlag     <= 1'b0;
      ofFlag     <= 1'b0;
      shiftCount <= '0;
    end else begin
      if (strobes.ccWr) ccFlag     <= ccNext;
      if (strobes.ofWr) ofFlag     <= arithOf;
      if (strobes.scWr) shiftCount <= shamt;
    end
  end

  AST_SC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.scWr |=> shiftCount == $past(shamt)); // R7
  AST_OF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.unit != U_ARITH) |=> $stable(ofFlag)); // R5

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               valid,
  input  logic [3:0]         opcode,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  result,
  output logic               ccFlag,
  output logic               ofFlag,
  output logic [SHAMT_W-1:0] shiftCount
);

  aluCtrl_t strobes;

  alu_ctrl i_ctrl (
    .valid   (valid),
    .opcode  (opcode),
    .strobes (strobes)
  );

  alu_datapath #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .srcA       (srcA),
    .srcB       (srcB),
    .imm        (imm),
    .result     (result),
    .ccFlag     (ccFlag),
    .ofFlag     (ofFlag),
    .shiftCount (shiftCount)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable({ccFlag, ofFlag, shiftCount})); // R9
  AST_SC_ONLY_SHR: assert property (@(posedge clk) disable iff (!rstN)
    !(valid && opcode == OP_SHR) |=> $stable(shiftCount)); // R9
  AST_ADDU_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode == OP_ADDU) |=> ccFlag == ofFlag); // R2
  AST_SUBU_OPPOSITE: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode == OP_SUBU) |=> ccFlag != ofFlag); // R4
  AST_SHIFT_KEEPS_CC: assert property (@(posedge clk) disable iff (!rstN)
    (opcode[3:2] == 2'b11) |=> $stable(ccFlag)); // R9
  AST_ZERO_SETS_CC: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode[3:2] != 2'b11 && opcode[3:2] != 2'b00 && result == '0) |=> ccFlag); // R5

endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        ccFlag;
  logic        ofFlag;
  logic [4:0]  shiftCount;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic       mCc = 1'b0;
  logic       mOf = 1'b0;
  logic [4:0] mSc = '0;

  always #4 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rstN(rstN), .valid(valid), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .imm(imm),
    .result(result), .ccFlag(ccFlag), .ofFlag(ofFlag), .shiftCount(shiftCount)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd6, 4'd8, 4'd10: return "R5";
      4'd5, 4'd7, 4'd9, 4'd11: return "R6";
      4'd15: return "R8";
      default: return "R7";
    endcase
  endfunction

  // Reference model: computes the result and the next architectural state.
  task automatic applyOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic v);
    logic [31:0] expRes;
    logic        nCc, nOf;
    logic [4:0]  nSc;
    longint      wide;
    logic [31:0] hiv;
    logic [63:0] pair;
    logic [32:0] usum;
    string       req;
    nCc = mCc; nOf = mOf; nSc = mSc;
    hiv = {im, 16'h0000};
    pair = {a, b};
    req = reqOf(op);
    case (op)
      4'd0: begin
        expRes = a + b;
        wide = longint'($signed(a)) + longint'($signed(b));
        nOf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        nCc = $signed(b) < $signed(32'(0) - a);
      end
      4'd1: begin
        usum = {1'b0, a} + {1'b0, b};
        expRes = usum[31:0];
        nCc = usum[32]; nOf = usum[32];
      end
      4'd2: begin
        expRes = a - b;
        wide = longint'($signed(a)) - longint'($signed(b));
        nOf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        nCc = $signed(b) > $signed(a);
      end
      4'd3: begin
        expRes = a - b;
        nCc = (b <= a); nOf = !(b <= a);
      end
      4'd4:  expRes = a & b;
      4'd5:  expRes = hiv & b;
      4'd6:  expRes = ~a & b;
      4'd7:  expRes = ~hiv & b;
      4'd8:  expRes = a | b;
      4'd9:  expRes = hiv | b;
      4'd10: expRes = a ^ b;
      4'd11: expRes = hiv ^ b;
      4'd12: expRes = b << (a & 32'd31);
      4'd13: begin expRes = b >> (a & 32'd31); nSc = a[4:0]; end
      4'd14: expRes = $unsigned($signed(b) >>> (a & 32'd31));
      default: begin pair = pair >> mSc; expRes = pair[31:0]; end
    endcase
    if (op >= 4'd4 && op <= 4'd11) nCc = (expRes == 32'd0);
    @(negedge clk);
    opcode = op; srcA = a; srcB = b; imm = im; valid = v;
    #1;
    check(req, "result", result, expRes);
    @(posedge clk);
    #1;
    if (v) begin mCc = nCc; mOf = nOf; mSc = nSc; end
    check(v ? req : "R9", "ccFlag", {31'd0, ccFlag}, {31'd0, mCc});
    check(v ? req : "R9", "ofFlag", {31'd0, ofFlag}, {31'd0, mOf});
    check(v ? req : "R9", "shiftCount", {27'd0, shiftCount}, {27'd0, mSc});
  endtask

  task automatic testReset();
    valid = 1'b1; opcode = 4'd13; srcA = 32'd7;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "cc in reset", {31'd0, ccFlag}, 32'd0);
    check("R10", "of in reset", {31'd0, ofFlag}, 32'd0);
    check("R10", "sc in reset", {27'd0, shiftCount}, 32'd0);
    @(negedge clk);
    valid = 1'b0; rstN = 1'b1;
  endtask

  task automatic testAddSigned();
    applyOp(4'd0, 32'h7fffffff, 32'h00000001, 16'h0, 1'b1); // R1 positive overflow
    applyOp(4'd0, 32'h80000000, 32'h80000000, 16'h0, 1'b1); // R1 negative overflow
    applyOp(4'd0, 32'h00000005, 32'hfffffffd, 16'h0, 1'b1); // R1 5 + -3
    applyOp(4'd0, 32'h00000003, 32'hfffffff0, 16'h0, 1'b1); // R1 srcB < -srcA
    applyOp(4'd0, 32'h80000000, 32'h00000000, 16'h0, 1'b1); // R1 negation wraps
  endtask

  task automatic testAddUnsigned();
    applyOp(4'd1, 32'hffffffff, 32'h00000001, 16'h0, 1'b1); // R2 carry
    applyOp(4'd1, 32'h12345678, 32'h00000001, 16'h0, 1'b1); // R2 no carry
  endtask

  task automatic testSubSigned();
    applyOp(4'd2, 32'h80000000, 32'h00000001, 16'h0, 1'b1); // R3 overflow
    applyOp(4'd2, 32'h00000001, 32'h00000002, 16'h0, 1'b1); // R3 srcB > srcA
    applyOp(4'd2, 32'h00000004, 32'h00000004, 16'h0, 1'b1); // R3 equal
  endtask

  task automatic testSubUnsigned();
    applyOp(4'd3, 32'h00000009, 32'h00000009, 16'h0, 1'b1); // R4 equal sets CC
    applyOp(4'd3, 32'h00000001, 32'h00000002, 16'h0, 1'b1); // R4 borrow
    applyOp(4'd3, 32'hffffffff, 32'h00000000, 16'h0, 1'b1); // R4
  endtask

  task automatic testLogical();
    applyOp(4'd0, 32'h7fffffff, 32'h00000001, 16'h0, 1'b1); // set OF first
    applyOp(4'd4, 32'hf0f0f0f0, 32'h0f0f0f0f, 16'h0, 1'b1); // R5 zero result, OF kept
    applyOp(4'd6, 32'hffff0000, 32'h0000ffff, 16'h0, 1'b1); // R5 and-not
    applyOp(4'd8, 32'h00000000, 32'h00000000, 16'h0, 1'b1); // R5 or zero
    applyOp(4'd10, 32'hdeadbeef, 32'hdeadbeef, 16'h0, 1'b1); // R5 xor zero
    applyOp(4'd10, 32'hdeadbeef, 32'h00000001, 16'h0, 1'b1); // R5 xor nonzero
  endtask

  task automatic testHighImm();
    applyOp(4'd5, 32'h0, 32'h1234ffff, 16'h00f0, 1'b1); // R6
    applyOp(4'd7, 32'h0, 32'hffff1111, 16'hff00, 1'b1); // R6 inverted upper half
    applyOp(4'd9, 32'hffffffff, 32'h00000042, 16'habcd, 1'b1); // R6 srcA ignored
    applyOp(4'd11, 32'h0, 32'habcd0000, 16'habcd, 1'b1); // R6 zero
  endtask

  task automatic testShifts();
    applyOp(4'd12, 32'h00000021, 32'h80000003, 16'h0, 1'b1); // R7 amount masked to 1
    applyOp(4'd14, 32'h00000004, 32'h80000000, 16'h0, 1'b1); // R7 sign fill
    applyOp(4'd13, 32'h000000e8, 32'h80000000, 16'h0, 1'b1); // R7 loads SC=8
    applyOp(4'd15, 32'h000000ab, 32'h12345678, 16'h0, 1'b1); // R8 uses SC=8
    applyOp(4'd13, 32'h00000000, 32'h0000ffff, 16'h0, 1'b1); // R7 SC=0
    applyOp(4'd15, 32'hcafef00d, 32'h11111111, 16'h0, 1'b1); // R8 shift 0
    applyOp(4'd13, 32'h0000001f, 32'hffffffff, 16'h0, 1'b1); // R7 SC=31
    applyOp(4'd15, 32'hcafef00d, 32'h11111111, 16'h0, 1'b1); // R8 shift 31
  endtask

  task automatic testValidGate();
    applyOp(4'd3, 32'h1, 32'h2, 16'h0, 1'b1);
    applyOp(4'd1, 32'hffffffff, 32'hffffffff, 16'h0, 1'b0); // R9 no update
    applyOp(4'd13, 32'h00000005, 32'h1, 16'h0, 1'b0);       // R9 SC unchanged
    applyOp(4'd4, 32'h0, 32'h0, 16'h0, 1'b0);               // R9 CC unchanged
    applyOp(4'd12, 32'h3, 32'h1, 16'h0, 1'b1);              // R9 shift keeps CC/OF
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      applyOp(4'($urandom), ra, rb, 16'($urandom), ($urandom % 8) != 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testAddSigned();
    testAddUnsigned();
    testSubSigned();
    testSubUnsigned();
    testLogical();
    testHighImm();
    testShifts();
    testValidGate();
    testRandom();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule